// File: doc/BRIEF.md
# Configuration Access Address Translator

This block turns a configuration-space request, made of a bus number, a device number, a function number and a register offset, into the address where the access must land and into the settings that the outbound translation region needs. Requests on bus 0 go straight to the controller's own register window. Requests on any other bus go through a fixed outbound window, and the block produces both the type code and the target word for that window.

A fixed topology rule decides whether a request is valid. Bus 0 holds only devices 0 and 1, and bus 1 holds only device 0. An invalid read is not sent downstream: the block returns all-ones data for it at once. An invalid write is rejected with an error flag. When a downstream read completes with a fault, the block returns all-ones in place of the returned data.

Each request strobe produces exactly one registered result pulse on the next cycle. Completions come back on a separate input and give a registered read-data pulse on the next cycle.

Top module: `cfg_xlate`

## Requirements
- R1: A request is invalid when the bus is 0 and the device is above 1, or when the bus is 1 and the device is above 0. Every other combination is valid.
- R2: For an invalid read (`req_wr`=0), the result has `out_skip`=1, `out_err`=0, address, type and target all 0. In the same cycle, `rd_vld`=1 with `rd_data`=0xFFFFFFFF.
- R3: For an invalid write (`req_wr`=1), the result has `out_err`=1 and `out_skip`=1, with address, type and target all 0. No read data is produced.
- R4: A valid request on bus 0 or 1 gives `out_type`=4 (type 0 configuration). A valid request on bus 2 or above gives `out_type`=5 (type 1 configuration).
- R5: A valid bus 0 request gives `out_addr` = LOCAL_BASE (default 0x01FFC000) plus the aligned offset, and `out_target`=0.
- R6: A valid request on any other bus gives `out_addr` = IO_BASE + 16 MiB − 1 MiB (default 0x01F00000) plus the aligned offset. It also gives `out_target` = bus in bits 31:24, device in bits 23:19, function in bits 18:16, and zeros in bits 15:0.
- R7: Bits 1:0 of the 12-bit offset are ignored. The offset is aligned down to a multiple of 4 before it is added to the base.
- R8: `out_vld` is high for exactly one cycle, one cycle after each cycle in which `req_vld` is high. While `out_vld` is low, every result field is 0.
- R9: One cycle after `cpl_vld`, `rd_vld`=1. `rd_data` is 0xFFFFFFFF if `cpl_fault` was set, and `cpl_data` otherwise.
- R10: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_ofs | input | 12 | Register byte offset |
| cpl_vld | input | 1 | Downstream read completion strobe |
| cpl_fault | input | 1 | Downstream access faulted |
| cpl_data | input | 32 | Downstream read data |
| out_vld | output | 1 | Result pulse |
| out_addr | output | 32 | Access address |
| out_type | output | 3 | Configuration type code (4 or 5) |
| out_target | output | 32 | Outbound region target word |
| out_err | output | 1 | Invalid write rejected |
| out_skip | output | 1 | No downstream access issued |
| rd_vld | output | 1 | Read data pulse |
| rd_data | output | 32 | Read data |

## Verification
Any fault in the validity decode, the base selection or the type choice shows up at the ports on the very next cycle. It appears as a wrong `out_addr`, `out_type` or `out_target`, or as a missing or extra all-ones read pulse. Offsets with nonzero low bits show a dropped alignment at once. A result field that is not cleared shows up as nonzero data on an idle cycle. A completion path that leaks stale data shows up as non-all-ones data one cycle after a faulted completion.

// File: rtl/cfg_xlate.sv
module cfg_xlate #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int OFS_W = 12,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter logic [AW-1:0] LOCAL_BASE = 32'h01FF_C000,
  parameter logic [AW-1:0] IO_BASE    = 32'h0100_0000,
  parameter int SPAN_LOG2 = 24,
  parameter int WIN_LOG2  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic             req_wr,
  input  logic [BUS_W-1:0] req_bus,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [FN_W-1:0]  req_fn,
  input  logic [OFS_W-1:0] req_ofs,
  input  logic             cpl_vld,
  input  logic             cpl_fault,
  input  logic [DW-1:0]    cpl_data,
  output logic             out_vld,
  output logic [AW-1:0]    out_addr,
  output logic [2:0]       out_type,
  output logic [AW-1:0]    out_target,
  output logic             out_err,
  output logic             out_skip,
  output logic             rd_vld,
  output logic [DW-1:0]    rd_data
);
  localparam logic [AW-1:0] WIN_BASE = IO_BASE + AW'(1 << SPAN_LOG2) - AW'(1 << WIN_LOG2);
  localparam int TGT_PAD = AW - BUS_W - DEV_W - FN_W;
  localparam logic [2:0] TYPE0 = 3'd4;
  localparam logic [2:0] TYPE1 = 3'd5;

  wire bus0 = (req_bus == '0);
  wire bus1 = (req_bus == BUS_W'(1));
  wire bad  = (bus0 && req_dev > DEV_W'(1)) || (bus1 && req_dev != '0);

  wire [AW-1:0] ofs_al  = AW'({req_ofs[OFS_W-1:2], 2'b00});
  wire [AW-1:0] addr_n  = (bus0 ? LOCAL_BASE : WIN_BASE) + ofs_al;
  wire [AW-1:0] tgt_n   = bus0 ? '0 : {req_bus, req_dev, req_fn, {TGT_PAD{1'b0}}};
  wire [2:0]    type_n  = (req_bus < BUS_W'(2)) ? TYPE0 : TYPE1;
  wire          bad_rd  = req_vld && !req_wr && bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld    <= 1'b0;
      out_addr   <= '0;
      out_type   <= '0;
      out_target <= '0;
      out_err    <= 1'b0;
      out_skip   <= 1'b0;
    end else begin
      out_vld    <= req_vld;
      out_addr   <= (req_vld && !bad) ? addr_n : '0;
      out_type   <= (req_vld && !bad) ? type_n : '0;
      out_target <= (req_vld && !bad) ? tgt_n  : '0;
      out_err    <= req_vld && bad && req_wr;
      out_skip   <= req_vld && bad;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld  <= bad_rd || cpl_vld;
      if (cpl_vld && !cpl_fault) rd_data <= cpl_data;
      else if (cpl_vld || bad_rd) rd_data <= '1;
      else rd_data <= '0;
    end
  end

  // R8
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(req_vld));
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_addr == '0 && out_target == '0 && out_type == '0 && !out_err && !out_skip));
  // R3
  err_implies_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_vld && out_skip && out_addr == '0));
  // R4
  type_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_skip) |-> (out_type == TYPE0 || out_type == TYPE1));
  // R7
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_addr[1:0] == 2'b00);
  // R9
  fault_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_vld && cpl_fault) |=> (rd_vld && rd_data == '1));
  // R2
  bad_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_skip && !out_err) |-> (rd_vld && rd_data == '1));
endmodule

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_vld = 1'b0, req_wr = 1'b0;
  logic [7:0] req_bus = '0;
  logic [4:0] req_dev = '0;
  logic [2:0] req_fn = '0;
  logic [11:0] req_ofs = '0;
  logic cpl_vld = 1'b0, cpl_fault = 1'b0;
  logic [31:0] cpl_data = '0;
  logic out_vld, out_err, out_skip, rd_vld;
  logic [31:0] out_addr, out_target, rd_data;
  logic [2:0] out_type;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [2:0]  ty;
    logic [31:0] tgt;
    logic        err;
    logic        skip;
    string       tag;
  } oexp_t;
  typedef struct {
    logic [31:0] d;
    string       tag;
  } rexp_t;
  oexp_t oq[$];
  rexp_t rq[$];

  always #4 clk = ~clk;

  cfg_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn), .req_ofs(req_ofs),
    .cpl_vld(cpl_vld), .cpl_fault(cpl_fault), .cpl_data(cpl_data),
    .out_vld(out_vld), .out_addr(out_addr), .out_type(out_type),
    .out_target(out_target), .out_err(out_err), .out_skip(out_skip),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input bit wr, input int b, input int d, input int f, input int o, input string tag);
    oexp_t e;
    rexp_t r;
    bit bad;
    @(negedge clk);
    req_vld = 1'b1; req_wr = wr;
    req_bus = 8'(b); req_dev = 5'(d); req_fn = 3'(f); req_ofs = 12'(o);
    bad = (b == 0 && d > 1) || (b == 1 && d != 0);
    e.tag = tag;
    if (bad) begin
      e.addr = 0; e.ty = 0; e.tgt = 0; e.err = wr; e.skip = 1'b1;
      if (!wr) begin r.d = 32'hFFFF_FFFF; r.tag = tag; rq.push_back(r); end
    end else begin
      e.err = 1'b0; e.skip = 1'b0;
      e.ty = (b < 2) ? 3'd4 : 3'd5;
      e.addr = ((b == 0) ? 32'h01FF_C000 : 32'h01F0_0000) + 32'(o & 32'hFFC);
      e.tgt = (b == 0) ? 32'h0 : ((32'(b) << 24) | (32'(d) << 19) | (32'(f) << 16));
    end
    oq.push_back(e);
  endtask

  task automatic cpl(input bit flt, input logic [31:0] d, input string tag);
    rexp_t r;
    @(negedge clk);
    req_vld = 1'b0;
    cpl_vld = 1'b1; cpl_fault = flt; cpl_data = d;
    r.d = flt ? 32'hFFFF_FFFF : d; r.tag = tag;
    rq.push_back(r);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_vld = 1'b0; cpl_vld = 1'b0; cpl_fault = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_vld) begin
        if (oq.size() == 0) chk(1'b0, "R8 unexpected result", 32'(out_vld), 32'h0);
        else begin
          oexp_t e;
          e = oq.pop_front();
          chk(out_addr == e.addr, {e.tag, " addr"}, out_addr, e.addr);
          chk(out_type == e.ty, {e.tag, " type"}, 32'(out_type), 32'(e.ty));
          chk(out_target == e.tgt, {e.tag, " target"}, out_target, e.tgt);
          chk(out_err == e.err && out_skip == e.skip, {e.tag, " err/skip"},
              {30'h0, out_err, out_skip}, {30'h0, e.err, e.skip});
        end
      end else if (out_addr != 0 || out_target != 0 || out_type != 0 || out_err || out_skip) begin
        chk(1'b0, "R8 idle fields nonzero", out_addr, 32'h0);
      end
      if (rd_vld) begin
        if (rq.size() == 0) chk(1'b0, "R3 unexpected read data", rd_data, 32'h0);
        else begin
          rexp_t r;
          r = rq.pop_front();
          chk(rd_data == r.d, {r.tag, " rdata"}, rd_data, r.d);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 outputs clear in reset
    chk(out_vld == 0 && rd_vld == 0 && out_addr == 0 && rd_data == 0 && out_target == 0,
        "R10 reset state", out_addr | rd_data, 32'h0);
    rst_n = 1'b1;
    idle(2);
    send(0, 0, 0, 0, 12'h010, "R5 bus0 dev0 read");
    send(1, 0, 1, 2, 12'h104, "R5 bus0 dev1 write");
    send(0, 0, 2, 0, 12'h000, "R1 R2 bus0 dev2 read");
    send(1, 0, 31, 7, 12'h020, "R1 R3 bus0 dev31 write");
    send(0, 1, 0, 5, 12'h044, "R4 R6 bus1 dev0 read");
    send(0, 1, 1, 0, 12'h008, "R1 R2 bus1 dev1 read");
    send(1, 1, 5, 0, 12'h008, "R1 R3 bus1 dev5 write");
    send(1, 2, 7, 3, 12'h0FC, "R4 R6 bus2 write");
    send(0, 255, 31, 7, 12'hFFF, "R6 R7 bus255 max offset");
    send(0, 3, 4, 1, 12'h123, "R7 offset low bits");
    send(0, 3, 4, 1, 12'h120, "R7 offset aligned");
    send(0, 0, 1, 0, 12'h7FE, "R7 bus0 unaligned");
    idle(2);
    cpl(1'b0, 32'h1234_5678, "R9 good completion");
    cpl(1'b1, 32'hDEAD_BEEF, "R9 faulted completion");
    cpl(1'b0, 32'h0000_0000, "R9 zero completion");
    idle(1);
    send(1, 4, 0, 0, 12'h0, "R8 isolated pulse");
    idle(4);
    chk(oq.size() == 0 && rq.size() == 0, "R8 all results delivered",
        32'(oq.size() + rq.size()), 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule